// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

The block gathers 32 external interrupt request lines into one processor interrupt. Each line passes through a synchroniser. Each line can then be set to level or edge sensing and to active-high or active-low polarity. The qualified requests appear in a read-only summary register. The summary is filtered by a per-variant valid-line parameter, and lines 20 to 30 are always forced off. The single interrupt output is a registered OR of the summary bits whose enable bit is set.

Software dismisses a line by holding the line's bit at 1 in a dismiss register, then writing 0 to that register again. A separate key register raises a system reset request for a fixed number of cycles. This happens only when the exact key value is written.

The bus side is a plain 32-bit register port. Writes are strobed by `wr_en_i` and take effect on that clock edge. Reads are combinational from `addr_i`.

Top module: `irqh_top`

## Requirements
- R1: After reset, the enable, trigger-mode, polarity and dismiss registers read 0, `irq_o` is 0 and `sys_rst_o` is 0.
- R2: The byte offsets are: 0x00 summary (read-only, writes ignored), 0x04 enable, 0x08 trigger-mode, 0x0C polarity, 0x10 dismiss, 0x14 reset key (reads 0). A write lands on the clock edge where `wr_en_i` is high.
- R3: A raw line change reaches the summary register after two clock edges. It is not visible after one.
- R4: A polarity bit of 1 makes the line active when the input is high. A polarity bit of 0 makes it active when the input is low.
- R5: With its trigger-mode bit at 0, a line's summary bit follows its active level, both rising and falling.
- R6: With its trigger-mode bit at 1, a transition from inactive to active sets a sticky pending bit. That bit stays set after the input returns to inactive.
- R7: While a line's dismiss bit is 1, its summary bit reads 0 and its edge latch is cleared. After 0 is written back, a level line reappears if it is still active. An edge line stays clear until a new edge arrives.
- R8: Summary bit i reads 0 whenever bit i of the `VALID_MASK` parameter is 0.
- R9: Summary bits 20 to 30 always read 0 and never assert `irq_o`, whatever `VALID_MASK`, the inputs and the enables hold.
- R10: `irq_o` is the registered OR of (summary AND enable). After a write that clears the enables, it is 0 by the second clock edge.
- R11: Writing 0x0000DEAD to offset 0x14 holds `sys_rst_o` high for exactly 16 cycles, starting at the write edge. Any other value at that offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | 32 | Asynchronous raw request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt to the processor |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench targets the places where the line logic can go quietly wrong. A design with a missing synchroniser stage would show requests one cycle early. A design that detected edges from the wrong polarity would latch on release instead of on assertion. One that cleared the edge latch only on the dismiss write, and not for as long as the bit is held, would leave edge lines pending after release. A design that ANDed the valid mask without forcing off the reserved lines would let lines 20 to 30 reach the output when the variant mask has those bits set. The reset key is driven with a wrong value and with the right one, and the pulse is counted cycle by cycle, to catch a key compare on too few bits or an off-by-one in the pulse length.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_REQ = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_EN  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TRG = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_POL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIS = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_RST = 5'h14;

  localparam logic [REG_W-1:0] RSVD_LINES = 32'h7FF0_0000;
  localparam logic [REG_W-1:0] RST_KEY    = 32'h0000_DEAD;

  typedef struct packed {
    logic [REG_W-1:0] en;
    logic [REG_W-1:0] trg;
    logic [REG_W-1:0] pol;
    logic [REG_W-1:0] dis;
  } cfg_t;
endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqh_lines.sv
module irqh_lines #(
  parameter int unsigned     W   = 32,
  parameter logic [W-1:0]    VLD = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] trg_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] dis_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] req_o,
  output logic         irq_o
);
  logic [W-1:0] act;
  logic [W-1:0] pend;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic act_prev_q;
    logic edge_q;

    assign act[i] = (lvl_i[i] == pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_prev_q <= 1'b1;
        edge_q     <= 1'b0;
      end else begin
        act_prev_q <= act[i];
        // latch cleared while dismissed or in level mode
        edge_q     <= trg_i[i] & ~dis_i[i] & (edge_q | (act[i] & ~act_prev_q));
      end
    end

    assign pend[i] = ~dis_i[i] & (trg_i[i] ? edge_q : act[i]);
  end

  assign req_o = pend & VLD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(req_o & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqh_regs.sv
module irqh_regs
  import irqh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  req_i,
  output cfg_t              cfg_o,
  output logic              key_hit_o,
  output logic [REG_W-1:0]  rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_EN:  cfg_q.en  <= wdata_i;
        OFF_TRG: cfg_q.trg <= wdata_i;
        OFF_POL: cfg_q.pol <= wdata_i;
        OFF_DIS: cfg_q.dis <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFF_REQ: rdata_o = req_i;
      OFF_EN:  rdata_o = cfg_q.en;
      OFF_TRG: rdata_o = cfg_q.trg;
      OFF_POL: rdata_o = cfg_q.pol;
      OFF_DIS: rdata_o = cfg_q.dis;
      default: rdata_o = '0;
    endcase
  end

  assign key_hit_o = wr_en_i && (addr_i == OFF_RST) && (wdata_i == RST_KEY);
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/irqh_rst_gen.sv
module irqh_rst_gen #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_req_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= CW'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign rst_req_o = (cnt_q != '0);
endmodule

// File: rtl/irqh_top.sv
module irqh_top
  import irqh_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID_MASK  = 32'h800F_FFFF,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      RST_LEN     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  irq_raw_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam logic [REG_W-1:0] VLD_EFF = VALID_MASK & ~RSVD_LINES;

  logic [REG_W-1:0] lvl_sync;
  logic [REG_W-1:0] req;
  cfg_t             cfg;
  logic             key_hit;

  irqh_sync #(
    .W      (REG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_raw_i),
    .q_o    (lvl_sync)
  );

  irqh_lines #(
    .W   (REG_W),
    .VLD (VLD_EFF)
  ) u_lines (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_sync),
    .trg_i  (cfg.trg),
    .pol_i  (cfg.pol),
    .dis_i  (cfg.dis),
    .en_i   (cfg.en),
    .req_o  (req),
    .irq_o  (irq_o)
  );

  irqh_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .req_i     (req),
    .cfg_o     (cfg),
    .key_hit_o (key_hit),
    .rdata_o   (rdata_o)
  );

  irqh_rst_gen #(
    .LEN (RST_LEN)
  ) u_rst_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (key_hit),
    .rst_req_o (sys_rst_o)
  );
endmodule

// File: rtl/irqh_chk.sv
module irqh_chk
  import irqh_pkg::*;
#(
  parameter int unsigned RST_LEN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic              sys_rst_o
);
  logic        key_wr;
  int unsigned hi_cnt;

  assign key_wr = wr_en_i && (addr_i == OFF_RST) && (wdata_i == RST_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 0;
    else if (key_wr)    hi_cnt <= 0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + 1;
  end

  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_REQ) |-> ((rdata_o & RSVD_LINES) == '0));

  assert_mask_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EN && wdata_i == '0) |-> ##2 !irq_o);

  assert_dismiss_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIS && wdata_i == '1) ##1 !(wr_en_i && addr_i == OFF_DIS)
      |=> !irq_o);

  assert_pulse_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(key_wr));

  assert_pulse_max_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (hi_cnt < RST_LEN));

  assert_pulse_len_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_cnt == RST_LEN));
endmodule

bind irqh_top irqh_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/irqh_top_bench.sv
module irqh_top_bench;
  import irqh_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          QP         = CLK_PERIOD / 4;
  localparam logic [31:0] VMASK      = 32'hFFFF_DFFF;
  localparam logic [31:0] VEFF       = VMASK & ~32'h7FF0_0000;
  localparam int          RLEN       = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = OFF_REQ;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        srst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irqh_top #(.VALID_MASK(VMASK), .SYNC_STAGES(2), .RST_LEN(RLEN)) u_irqh_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_raw_i(raw), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_s1 = '0, m_s2 = '0, m_en = '0, m_trg = '0, m_pol = '0, m_dis = '0;
  logic [31:0] m_edge = '0, m_pact = '1;
  logic        m_irq = 1'b0;
  int          m_rc = 0;

  function automatic logic [31:0] m_act();
    return ~(m_s2 ^ m_pol);
  endfunction

  function automatic logic [31:0] m_req();
    return (((~m_trg) & m_act()) | (m_trg & m_edge)) & ~m_dis & VEFF;
  endfunction

  function automatic logic [31:0] m_rd(logic [4:0] a);
    case (a)
      OFF_REQ: return m_req();
      OFF_EN:  return m_en;
      OFF_TRG: return m_trg;
      OFF_POL: return m_pol;
      OFF_DIS: return m_dis;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_en = '0; m_trg = '0; m_pol = '0; m_dis = '0;
      m_edge = '0; m_pact = '1; m_irq = 1'b0; m_rc = 0;
    end else begin
      logic [31:0] a;
      logic [31:0] rq;
      a  = m_act();
      rq = m_req();
      m_irq  = |(rq & m_en);
      m_edge = m_trg & ~m_dis & (m_edge | (a & ~m_pact));
      m_pact = a;
      if (m_rc > 0) m_rc--;
      if (wr) begin
        case (addr)
          OFF_EN:  m_en  = wd;
          OFF_TRG: m_trg = wd;
          OFF_POL: m_pol = wd;
          OFF_DIS: m_dis = wd;
          OFF_RST: if (wd == 32'h0000_DEAD) m_rc = RLEN;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = raw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #(QP);
      check("R10 per-cycle irq_o", 32'(irq), 32'(m_irq));
      check("R11 per-cycle sys_rst_o", 32'(srst), 32'(m_rc > 0));
      check("R2 per-cycle rdata_o", rdata, m_rd(addr));
    end
  end

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wd = d;
    @(negedge clk); wr = 1'b0; addr = OFF_REQ; wd = '0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
    addr = OFF_REQ;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_raw(logic [31:0] v);
    @(negedge clk); raw = v;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq_o after reset", 32'(irq), 32'h0);
    check("R1 sys_rst_o after reset", 32'(srst), 32'h0);
    rd_reg(OFF_EN, d);  check("R1 enable reset", d, 32'h0);
    rd_reg(OFF_TRG, d); check("R1 trigger reset", d, 32'h0);
    rd_reg(OFF_POL, d); check("R1 polarity reset", d, 32'h0);
    rd_reg(OFF_DIS, d); check("R1 dismiss reset", d, 32'h0);

    // low inputs with active-low default: all valid lines active
    idle(3);
    rd_reg(OFF_REQ, d);
    check("R8 variant mask drops line 13", d, 32'h800F_DFFF);
    check("R9 reserved bits clear", d & 32'h7FF0_0000, 32'h0);

    // R4 polarity
    wr_reg(OFF_POL, 32'h8000_0000); idle(3);
    rd_reg(OFF_REQ, d); check("R4 only line 31 active-high", d, 32'h000F_DFFF);
    wr_reg(OFF_POL, 32'hFFFF_FFFF); idle(3);
    rd_reg(OFF_REQ, d); check("R4 all active-high, inputs low", d, 32'h0);

    // R3 synchroniser latency
    set_raw(32'h0000_0020);
    rd_reg(OFF_REQ, d); check("R3 not visible after one edge", d, 32'h0);
    rd_reg(OFF_REQ, d); check("R3 visible after two edges", d, 32'h0000_0020);

    // R5 level, R10 combine
    wr_reg(OFF_EN, 32'h0000_0020); idle(2);
    check("R10 irq_o for enabled level line", 32'(irq), 32'h1);
    set_raw(32'h0); idle(4);
    rd_reg(OFF_REQ, d); check("R5 level follows input low", d, 32'h0);
    check("R5 irq_o drops with level", 32'(irq), 32'h0);

    // R10 masking
    set_raw(32'h0000_0020); idle(4);
    check("R10 irq_o high before mask", 32'(irq), 32'h1);
    wr_reg(OFF_EN, 32'h0); idle(1);
    check("R10 irq_o low after mask", 32'(irq), 32'h0);

    // R6 edge mode: line 7 rising, line 8 active-low (falling)
    set_raw(32'h0000_0100);
    wr_reg(OFF_POL, 32'hFFFF_FEFF);
    wr_reg(OFF_TRG, 32'h0000_0180);
    wr_reg(OFF_EN, 32'h0000_0180); idle(3);
    rd_reg(OFF_REQ, d); check("R6 no edge yet", d, 32'h0);
    @(negedge clk); raw = 32'h0000_0180;
    @(negedge clk); raw = 32'h0000_0100;
    idle(4);
    rd_reg(OFF_REQ, d); check("R6 sticky after pulse", d, 32'h0000_0080);
    check("R6 irq_o from edge line", 32'(irq), 32'h1);
    set_raw(32'h0); idle(4);
    rd_reg(OFF_REQ, d); check("R6 active-low falling edge", d, 32'h0000_0180);

    // R7 dismiss on edge lines
    wr_reg(OFF_DIS, 32'h0000_0080);
    rd_reg(OFF_REQ, d); check("R7 dismissed edge line reads 0", d, 32'h0000_0100);
    wr_reg(OFF_DIS, 32'h0); idle(2);
    rd_reg(OFF_REQ, d); check("R7 edge stays clear after release", d, 32'h0000_0100);
    wr_reg(OFF_DIS, 32'h0000_0100);
    wr_reg(OFF_DIS, 32'h0); idle(2);
    rd_reg(OFF_REQ, d); check("R7 both edge lines clear", d, 32'h0);
    check("R7 irq_o low after dismiss", 32'(irq), 32'h0);

    // R7 dismiss on a level line
    wr_reg(OFF_TRG, 32'h0);
    wr_reg(OFF_POL, 32'hFFFF_FFFF);
    set_raw(32'h0000_0020);
    wr_reg(OFF_EN, 32'h0000_0020); idle(3);
    wr_reg(OFF_DIS, 32'h0000_0020);
    rd_reg(OFF_REQ, d); check("R7 held dismiss hides level line", d, 32'h0);
    check("R7 irq_o low while dismissed", 32'(irq), 32'h0);
    wr_reg(OFF_DIS, 32'h0); idle(2);
    rd_reg(OFF_REQ, d); check("R7 level line returns on release", d, 32'h0000_0020);

    // R2 map behaviour
    wr_reg(OFF_REQ, 32'hFFFF_FFFF);
    rd_reg(OFF_EN, d);  check("R2 summary write leaves enable", d, 32'h0000_0020);
    rd_reg(OFF_REQ, d); check("R2 summary write ignored", d, 32'h0000_0020);
    rd_reg(OFF_TRG, d); check("R2 trigger unchanged", d, 32'h0);
    rd_reg(OFF_RST, d); check("R2 key register reads 0", d, 32'h0);

    // R9 reserved lines and R8 variant mask
    wr_reg(OFF_EN, 32'hFFFF_FFFF);
    set_raw(32'h7FF0_2000); idle(4);
    rd_reg(OFF_REQ, d); check("R9 reserved and invalid lines read 0", d, 32'h0);
    check("R9 irq_o stays low", 32'(irq), 32'h0);
    set_raw(32'h8000_0000); idle(4);
    rd_reg(OFF_REQ, d); check("R8 line 31 valid", d, 32'h8000_0000);
    check("R8 irq_o from line 31", 32'(irq), 32'h1);
    set_raw(32'h0);
    wr_reg(OFF_EN, 32'h0);

    // R11 reset key
    wr_reg(OFF_RST, 32'h0000_1234);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (srst) hi++;
    end
    check("R11 wrong key ignored", 32'(hi), 32'h0);
    wr_reg(OFF_RST, 32'h0000_DEAD);
    hi = srst ? 1 : 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (srst) hi++;
    end
    check("R11 pulse length", 32'(hi), 32'(RLEN));

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule